// File: doc/BRIEF.md
# Serial NOR Flash Identity Probe

This block asks an attached serial NOR flash for its identity and decides whether the answer fits an expected manufacturer/device pair. A one-cycle `start` launches a probe. The block first sends the identify opcode 0x9F over a byte-wide transmit stream. It then sends three or four fill bytes (0x00), picked by `long_mode`. The response stream returns one byte for each byte sent. The response to the opcode is thrown away and the rest are captured. The captured bytes are split into a 16-bit manufacturer ID and a 16-bit device ID. The manufacturer byte(s) are checked for odd parity, and the IDs are compared against `exp_mfr`/`exp_dev`. Either field of the expected pair may be a wildcard.

A successful read is kept in a per-mode cache. A later probe in the same mode is answered from the cache without touching the bus. A single-cycle `done` carries `match`, `parity_err` and the parsed IDs, which stay readable until the next result. Both transmit and response streams use valid/ready. The block holds `tx_valid` and `tx_data` steady until `tx_ready` is seen, and raises `rx_ready` only while it waits for the answer to the byte just sent, so the bus side can stall either stream for any number of cycles.

Top module: `flash_id_probe`

## Requirements
- R1: After reset `busy`, `done`, `cs_active`, `tx_valid` and `rx_ready` are all low.
- R2: An uncached probe sends byte 0x9F followed by 3 fill bytes of 0x00 when `long_mode`=0, or 4 fill bytes when `long_mode`=1, and keeps `cs_active` high whenever `tx_valid` is high.
- R3: When the first captured byte b0 is not 0x7F, the result is `mfr_id`={0x00,b0} and `dev_id`={b1,b2}; b3 is ignored.
- R4: When b0 is 0x7F, `mfr_id`={b0,b1}. `dev_id` is {b2,b3} in long mode and {0x00,b2} in short mode.
- R5: `parity_err` is high when b0 has an even number of ones, or when b0 is 0x7F and b1 has an even number of ones. Parity does not change `match`.
- R6: `match` is high when `mfr_id` equals `exp_mfr` and either `dev_id` equals `exp_dev` or `exp_dev` equals the device wildcard (default 0xFFFF).
- R7: When `exp_mfr` equals the manufacturer wildcard (default 0xFFFF), `match` is high for every `mfr_id` other than 0x0000 and 0x00FF.
- R8: After a successful read in a mode, a repeat probe in that mode sends no bytes and returns the cached result. The two modes are cached separately.
- R9: A one-cycle `cache_clr` invalidates both cache entries, so the next probe in each mode reads the bus again.
- R10: A response with `rx_err` high ends the probe with `done` high, `match`=0, `parity_err`=0 and both IDs zero, and leaves that mode uncached.
- R11: `done` is a one-cycle pulse and is seen with `busy` low. A `start` while `busy` is high is ignored and produces no second probe.
- R12: Under back-pressure `tx_valid` and `tx_data` stay unchanged until accepted. When idle, neither stream is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a probe (pulse) |
| long_mode | input | 1 | 0: three response bytes, 1: four |
| cache_clr | input | 1 | Invalidate both cache entries |
| exp_mfr | input | 16 | Expected manufacturer ID or wildcard |
| exp_dev | input | 16 | Expected device ID or wildcard |
| busy | output | 1 | Probe in progress |
| cs_active | output | 1 | Chip select request, held across the whole transaction |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Bus accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Response byte valid |
| rx_ready | output | 1 | Block accepts response byte |
| rx_data | input | 8 | Response byte |
| rx_err | input | 1 | Bus error flag qualifying the response |
| done | output | 1 | Result pulse |
| match | output | 1 | Identity matched |
| parity_err | output | 1 | Manufacturer byte parity violation |
| mfr_id | output | 16 | Parsed manufacturer ID |
| dev_id | output | 16 | Parsed device ID |

## Verification
The assertions assume that `exp_mfr` and `exp_dev` do not change from `start` until `done`. They also assume the bus side sends exactly one response per accepted transmit byte and raises `rx_valid` only after that byte has been taken. The bench works as a responder that follows this contract. It answers each accepted byte on the next cycle, stalls `tx_ready` on a fixed cadence to exercise back-pressure, and changes the expected pair only between probes.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_EVAL,
    ST_FAIL
  } probe_state_t;
endpackage

// File: rtl/probe_seq.sv
module probe_seq
  import flash_probe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  parameter int SHORT  = 3,
  parameter logic [BYTE_W-1:0] OPCODE = 8'h9F,
  parameter logic [BYTE_W-1:0] FILL   = 8'h00,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_mode,
  input  logic              hit,
  output logic              busy,
  output logic              cs_active,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_err,
  output logic              cap_we,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [BYTE_W-1:0] cap_data,
  output logic              commit,
  output logic              mode_q,
  output logic              eval,
  output logic              fail
);
  probe_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_d;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = mode_q ? CNT_W'(DEPTH) : CNT_W'(SHORT);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    tx_valid = 1'b0;
    tx_data  = (cnt_q == '0) ? OPCODE : FILL;
    rx_ready = 1'b0;
    cap_we   = 1'b0;
    cap_idx  = IDX_W'(cnt_q - CNT_W'(1));
    cap_data = rx_data;
    commit   = 1'b0;
    eval     = 1'b0;
    fail     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_d  = long_mode;
          cnt_d   = '0;
          state_d = hit ? ST_EVAL : ST_SEND;
        end
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          if (rx_err) begin
            state_d = ST_FAIL;
          end else begin
            cap_we = (cnt_q != '0);
            if (cnt_q == last_cnt) begin
              commit  = 1'b1;
              state_d = ST_EVAL;
            end else begin
              cnt_d   = cnt_q + CNT_W'(1);
              state_d = ST_SEND;
            end
          end
        end
      end
      ST_EVAL: begin
        eval    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FAIL: begin
        fail    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign cs_active = (state_q == ST_SEND) || (state_q == ST_WAIT);
endmodule

// File: rtl/id_cache.sv
module id_cache #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  parameter int MODES  = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int MODE_W = (MODES > 1) ? $clog2(MODES) : 1,
  localparam int LINE_W = DEPTH * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [BYTE_W-1:0] st_data,
  input  logic              commit,
  input  logic [MODE_W-1:0] commit_mode,
  input  logic [MODE_W-1:0] rd_mode,
  output logic [MODES-1:0]  valid,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] stage_q, stage_nx;
  logic [LINE_W-1:0] line_q [MODES];

  always_comb begin
    stage_nx = stage_q;
    if (st_we) stage_nx[st_idx*BYTE_W +: BYTE_W] = st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nx;
  end

  for (genvar m = 0; m < MODES; m++) begin : g_entry
    logic sel;
    assign sel = commit && (commit_mode == MODE_W'(m));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[m] <= '0;
        valid[m]  <= 1'b0;
      end else begin
        if (sel) line_q[m] <= stage_nx;
        if (clr)      valid[m] <= 1'b0;
        else if (sel) valid[m] <= 1'b1;
      end
    end
  end

  assign rd_line = line_q[rd_mode];
endmodule

// File: rtl/id_decode.sv
module id_decode #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 4,
  parameter logic [BYTE_W-1:0] CONT = 8'h7F,
  parameter logic [2*BYTE_W-1:0] MFR_ANY = 16'hFFFF,
  parameter logic [2*BYTE_W-1:0] DEV_ANY = 16'hFFFF,
  localparam int ID_W   = 2 * BYTE_W,
  localparam int LINE_W = DEPTH * BYTE_W
) (
  input  logic [LINE_W-1:0] line,
  input  logic              long_mode,
  input  logic [ID_W-1:0]   exp_mfr,
  input  logic [ID_W-1:0]   exp_dev,
  output logic [ID_W-1:0]   mfr,
  output logic [ID_W-1:0]   dev,
  output logic              par_err,
  output logic              match
);
  logic [BYTE_W-1:0] b0, b1, b2, b3;
  logic cont, mfr_eq, dev_ok, any_vendor;

  assign b0 = line[0*BYTE_W +: BYTE_W];
  assign b1 = line[1*BYTE_W +: BYTE_W];
  assign b2 = line[2*BYTE_W +: BYTE_W];
  assign b3 = line[3*BYTE_W +: BYTE_W];
  assign cont = (b0 == CONT);

  always_comb begin
    if (cont) begin
      mfr = {b0, b1};
      dev = long_mode ? {b2, b3} : {{BYTE_W{1'b0}}, b2};
    end else begin
      mfr = {{BYTE_W{1'b0}}, b0};
      dev = {b1, b2};
    end
  end

  assign par_err = !(^b0) || (cont && !(^b1));

  assign mfr_eq     = (mfr == exp_mfr);
  assign dev_ok     = (dev == exp_dev) || (exp_dev == DEV_ANY);
  assign any_vendor = (exp_mfr == MFR_ANY) && (mfr != '0) &&
                      (mfr != {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}});
  assign match      = (mfr_eq && dev_ok) || any_vendor;
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int BYTE_W    = 8,
  parameter int RSP_LONG  = 4,
  parameter int RSP_SHORT = 3,
  parameter logic [BYTE_W-1:0] OPCODE = 8'h9F,
  parameter logic [BYTE_W-1:0] FILL   = 8'h00,
  parameter logic [BYTE_W-1:0] CONT   = 8'h7F,
  parameter logic [2*BYTE_W-1:0] MFR_ANY = 16'hFFFF,
  parameter logic [2*BYTE_W-1:0] DEV_ANY = 16'hFFFF,
  localparam int ID_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_mode,
  input  logic              cache_clr,
  input  logic [ID_W-1:0]   exp_mfr,
  input  logic [ID_W-1:0]   exp_dev,
  output logic              busy,
  output logic              cs_active,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_err,
  output logic              done,
  output logic              match,
  output logic              parity_err,
  output logic [ID_W-1:0]   mfr_id,
  output logic [ID_W-1:0]   dev_id
);
  localparam int MODES  = 2;
  localparam int IDX_W  = $clog2(RSP_LONG);
  localparam int LINE_W = RSP_LONG * BYTE_W;

  logic              hit, cap_we, commit, mode_q, eval, fail;
  logic [IDX_W-1:0]  cap_idx;
  logic [BYTE_W-1:0] cap_data;
  logic [MODES-1:0]  valid;
  logic [LINE_W-1:0] line;
  logic [ID_W-1:0]   dec_mfr, dec_dev;
  logic              dec_par, dec_match;

  assign hit = valid[long_mode] && !cache_clr;

  probe_seq #(
    .BYTE_W(BYTE_W), .DEPTH(RSP_LONG), .SHORT(RSP_SHORT),
    .OPCODE(OPCODE), .FILL(FILL)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode), .hit(hit),
    .busy(busy), .cs_active(cs_active),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
    .commit(commit), .mode_q(mode_q), .eval(eval), .fail(fail)
  );

  id_cache #(.BYTE_W(BYTE_W), .DEPTH(RSP_LONG), .MODES(MODES)) i_cache (
    .clk(clk), .rst_n(rst_n), .clr(cache_clr),
    .st_we(cap_we), .st_idx(cap_idx), .st_data(cap_data),
    .commit(commit), .commit_mode(mode_q), .rd_mode(mode_q),
    .valid(valid), .rd_line(line)
  );

  id_decode #(
    .BYTE_W(BYTE_W), .DEPTH(RSP_LONG), .CONT(CONT),
    .MFR_ANY(MFR_ANY), .DEV_ANY(DEV_ANY)
  ) i_dec (
    .line(line), .long_mode(mode_q), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .mfr(dec_mfr), .dev(dec_dev), .par_err(dec_par), .match(dec_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      match      <= 1'b0;
      parity_err <= 1'b0;
      mfr_id     <= '0;
      dev_id     <= '0;
    end else begin
      done <= eval || fail;
      if (eval) begin
        match      <= dec_match;
        parity_err <= dec_par;
        mfr_id     <= dec_mfr;
        dev_id     <= dec_dev;
      end else if (fail) begin
        match      <= 1'b0;
        parity_err <= 1'b0;
        mfr_id     <= '0;
        dev_id     <= '0;
      end
    end
  end
endmodule

// File: rtl/probe_chk.sv
module probe_chk #(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] MFR_ANY = 16'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cs_active,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_ready,
  input logic              done,
  input logic              match,
  input logic [2*BYTE_W-1:0] exp_mfr,
  input logic [2*BYTE_W-1:0] mfr_id
);
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rx_ready);

  // R2
  cs_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> cs_active);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  any_vendor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && match && (exp_mfr == MFR_ANY) |->
      (mfr_id != '0) && (mfr_id != {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}}));
endmodule

bind flash_id_probe probe_chk #(.BYTE_W(BYTE_W), .MFR_ANY(MFR_ANY)) i_probe_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_active(cs_active),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .done(done), .match(match),
  .exp_mfr(exp_mfr), .mfr_id(mfr_id)
);

// File: tb/test_flash_id_probe.sv
module test_flash_id_probe;
  localparam logic [15:0] ANY = 16'hFFFF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, long_mode, cache_clr;
  logic [15:0] exp_mfr, exp_dev;
  logic busy, cs_active, tx_valid, tx_ready, rx_valid, rx_ready, rx_err;
  logic [7:0] tx_data, rx_data;
  logic done, match, parity_err;
  logic [15:0] mfr_id, dev_id;

  flash_id_probe i_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
    .cache_clr(cache_clr), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .busy(busy), .cs_active(cs_active), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .done(done), .match(match), .parity_err(parity_err),
    .mfr_id(mfr_id), .dev_id(dev_id)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] flash_b [4];
  int sent, first_b, fill_bad, cs_bad, got_done, extra_done;
  logic r_match, r_par;
  logic [15:0] r_mfr, r_dev;
  logic [15:0] e_mfr, e_dev;
  logic e_par, e_match;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ids(input bit lm, input logic [15:0] em, input logic [15:0] ed);
    logic c;
    c = (flash_b[0] == 8'h7F);
    e_mfr = c ? {flash_b[0], flash_b[1]} : {8'h00, flash_b[0]};
    if (c) e_dev = lm ? {flash_b[2], flash_b[3]} : {8'h00, flash_b[2]};
    else   e_dev = {flash_b[1], flash_b[2]};
    e_par = ($countones(flash_b[0]) % 2 == 0) ||
            (c && ($countones(flash_b[1]) % 2 == 0));
    e_match = ((e_mfr == em) && ((e_dev == ed) || (ed == ANY))) ||
              ((em == ANY) && (e_mfr > 16'h0000) && (e_mfr != 16'h00FF));
  endtask

  task automatic clear_cache();
    @(negedge clk); cache_clr = 1'b1;
    @(negedge clk); cache_clr = 1'b0;
  endtask

  task automatic run_probe(input bit lm, input int err_at, input bit poke);
    bit pend;
    int cyc;
    @(negedge clk); long_mode = lm; start = 1'b1;
    @(negedge clk); start = 1'b0;
    sent = 0; pend = 0; cyc = 0; got_done = 0; fill_bad = 0; cs_bad = 0;
    first_b = -1; extra_done = 0;
    while (!got_done && cyc < 300) begin
      if (done) begin
        got_done = 1;
        r_match = match; r_par = parity_err; r_mfr = mfr_id; r_dev = dev_id;
      end else begin
        if (tx_valid && !cs_active) cs_bad = 1;
        rx_valid = pend;
        rx_data  = (sent >= 2) ? flash_b[sent-2] : 8'hA5;
        rx_err   = pend && (sent >= 2) && (sent - 2 == err_at);
        tx_ready = (cyc % 3) != 1;
        start    = poke && (cyc == 4);
        if (pend && rx_ready) pend = 0;
        if (tx_valid && tx_ready) begin
          if (sent == 0) first_b = int'(tx_data);
          else if (tx_data != 8'h00) fill_bad = 1;
          sent++;
          pend = 1;
        end
        @(negedge clk);
        cyc++;
      end
    end
    rx_valid = 1'b0; rx_err = 1'b0; tx_ready = 1'b0; start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done || busy) extra_done = 1;
    end
  endtask

  task automatic probe_and_check(input bit lm, input logic [15:0] em,
                                 input logic [15:0] ed, input int want_sent);
    exp_mfr = em; exp_dev = ed;
    expect_ids(lm, em, ed);
    run_probe(lm, -1, 1'b0);
    chk("R11", "done seen", got_done, 1);
    chk(lm ? "R4" : "R3", "mfr_id", r_mfr, e_mfr);
    chk(lm ? "R4" : "R3", "dev_id", r_dev, e_dev);
    chk("R5", "parity_err", r_par, e_par);
    chk((em == ANY) ? "R7" : "R6", "match", r_match, e_match);
    chk("R2", "bytes sent", sent, want_sent);
    if (want_sent > 0) begin
      chk("R2", "opcode", first_b, 32'h9F);
      chk("R2", "fill/cs", fill_bad + cs_bad, 0);
    end
  endtask

  function automatic logic [15:0] pick_mfr(input int sel);
    case (sel)
      0, 1: return e_mfr;
      2:    return ANY;
      default: return e_mfr ^ 16'h0001;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; long_mode = 1'b0; cache_clr = 1'b0;
    exp_mfr = '0; exp_dev = '0; tx_ready = 1'b0; rx_valid = 1'b0;
    rx_err = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "cs_active", cs_active, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "rx_ready", rx_ready, 0);

    // R3 R5 R6 R7: sweep every first byte in short mode
    for (int i = 0; i < 256; i++) begin
      logic [15:0] em, ed;
      flash_b[0] = 8'(i); flash_b[1] = 8'(i) ^ 8'h5A;
      flash_b[2] = 8'(i + 3); flash_b[3] = 8'hC3;
      expect_ids(1'b0, 16'h0, 16'h0);
      em = pick_mfr(i % 4);
      ed = ((i % 4) == 1) ? ANY : (((i % 4) == 2) ? 16'h1234 : e_dev);
      clear_cache();
      probe_and_check(1'b0, em, ed, 4);
    end

    // R4 R5: long mode, continuation code on odd steps, sweep second byte
    for (int i = 0; i < 256; i++) begin
      logic [15:0] em, ed;
      flash_b[0] = (i % 2 == 1) ? 8'h7F : 8'(i);
      flash_b[1] = 8'(i); flash_b[2] = ~8'(i); flash_b[3] = 8'(i + 1);
      expect_ids(1'b1, 16'h0, 16'h0);
      em = pick_mfr((i / 2) % 4);
      ed = (((i / 2) % 4) == 1) ? ANY : e_dev ^ 16'(i % 3);
      clear_cache();
      probe_and_check(1'b1, em, ed, 5);
    end

    // R4 short mode with continuation: dev is zero-extended b2
    flash_b[0] = 8'h7F; flash_b[1] = 8'h9D; flash_b[2] = 8'h46; flash_b[3] = 8'h11;
    clear_cache();
    probe_and_check(1'b0, 16'h7F9D, 16'h0046, 4);
    chk("R4", "short cont match", r_match, 1);

    // R7 boundary: wildcard vendor rejects 0x00 and 0xFF
    flash_b[0] = 8'h00; flash_b[1] = 8'h12; flash_b[2] = 8'h34;
    clear_cache();
    probe_and_check(1'b0, ANY, 16'h1234, 4);
    chk("R7", "zero vendor", r_match, 0);
    flash_b[0] = 8'hFF;
    clear_cache();
    probe_and_check(1'b0, ANY, 16'h1234, 4);
    chk("R7", "ff vendor", r_match, 0);

    // R8 cache reuse, per-mode separation; R9 clear
    flash_b[0] = 8'hC2; flash_b[1] = 8'h20; flash_b[2] = 8'h17; flash_b[3] = 8'h00;
    clear_cache();
    probe_and_check(1'b0, 16'h00C2, 16'h2017, 4);
    flash_b[0] = 8'hEF; flash_b[1] = 8'h40; flash_b[2] = 8'h18; flash_b[3] = 8'h00;
    exp_mfr = 16'h00C2; exp_dev = 16'h2017;
    run_probe(1'b0, -1, 1'b0);
    chk("R8", "cached bytes sent", sent, 0);
    chk("R8", "cached mfr", r_mfr, 16'h00C2);
    chk("R8", "cached match", r_match, 1);
    probe_and_check(1'b1, 16'h00EF, 16'h4018, 5);
    run_probe(1'b0, -1, 1'b0);
    chk("R8", "short still cached", r_mfr, 16'h00C2);
    chk("R8", "short cached sent", sent, 0);
    clear_cache();
    probe_and_check(1'b0, 16'h00EF, 16'h4018, 4);
    clear_cache();
    probe_and_check(1'b1, 16'h00EF, 16'h4018, 5);
    chk("R9", "long refetched", sent, 5);

    // R10 bus error on second data byte
    clear_cache();
    flash_b[0] = 8'hC2; flash_b[1] = 8'h20; flash_b[2] = 8'h17;
    exp_mfr = 16'h00C2; exp_dev = 16'h2017;
    run_probe(1'b0, 1, 1'b0);
    chk("R10", "done on error", got_done, 1);
    chk("R10", "match", r_match, 0);
    chk("R10", "parity", r_par, 0);
    chk("R10", "ids", {r_mfr, r_dev}, 32'h0);
    chk("R10", "bytes before error", sent, 3);
    probe_and_check(1'b0, 16'h00C2, 16'h2017, 4);
    chk("R10", "not cached after error", sent, 4);

    // R11 start while busy ignored
    clear_cache();
    expect_ids(1'b0, 16'h00C2, 16'h2017);
    run_probe(1'b0, -1, 1'b1);
    chk("R11", "single probe bytes", sent, 4);
    chk("R11", "no second probe", extra_done, 0);
    chk("R11", "match", r_match, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule